// File: doc/BRIEF.md
# Programmable DRAM Refresh Scheduler

This block tells a DRAM controller when a refresh is due. Software loads a small control word that holds a run bit and a 3-bit stretch code. While the run bit is set, a cycle timer counts one refresh period. When the period ends, the block raises a refresh request toward the memory arbiter. The request stays up until the arbiter acknowledges it.

The period is a fixed base time plus a stretch of whole 1600 ns steps. The code is inverted: the largest code adds nothing and the smallest adds seven steps. Both the base time and the clock period are parameters, and the block turns nanoseconds into clock cycles itself. Every acknowledged request sets a sticky "refresh happened" flag. Software clears that flag with a data-less clear strobe.

Top module: `rfsh_sched`

## Requirements
- R1: While control bit 3 (run) is 0, `refresh_req` stays low no matter how long the block waits.
- R2: After a control write with run = 1, `refresh_req` rises exactly N clock edges after the write edge, where N = (BASE_INTERVAL_NS + (7 − code) × 1600) / CLK_PERIOD_NS and code is control bits 2:0. Code 7 adds no stretch and code 0 adds 11200 ns.
- R3: Once raised, `refresh_req` stays high for as long as `refresh_ack` is low.
- R4: An acknowledge drops `refresh_req` on the next edge, and the next request follows N edges after the acknowledge edge.
- R5: An acknowledged request sets `refresh_seen` on the acknowledge edge.
- R6: A pulse on `status_clr` clears `refresh_seen`.
- R7: When an acknowledge and `status_clr` fall in the same cycle, `refresh_seen` ends up set.
- R8: Reset clears the control word, `refresh_req` and `refresh_seen`. `ctrl_q` shows the stored control word and changes only on a write.
- R9: Clearing the run bit withdraws a pending request one edge after the control word changes. A later re-enable times a full fresh period.
- R10: An acknowledge that arrives while no request is pending has no effect on `refresh_seen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-up reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 4 | Bit 3 run, bits 2:0 stretch code |
| ctrl_q | output | 4 | Stored control word |
| status_clr | input | 1 | Clear strobe for the refresh flag |
| refresh_ack | input | 1 | Arbiter acknowledge |
| refresh_req | output | 1 | Refresh request |
| refresh_seen | output | 1 | Sticky flag: a refresh was serviced |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the sticky flag's set and clear. The bench raises `status_clr` in the very cycle it acknowledges a pending request, and then requires the flag to read 1. The second pair is withdrawal of a held request against a new timing run. The bench drops the run bit while a request is held and confirms the request falls one edge later. It then re-enables and requires a full, unshortened period.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam int CODE_W = 3;
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int STEP_NS = 1600;

  // number of 1600 ns stretch steps selected by an inverted code
  function automatic int unsigned stretch_steps(input logic [CODE_W-1:0] code);
    return CODE_MAX - int'(code);
  endfunction

  // full refresh period in clock cycles
  function automatic int unsigned period_cycles(input int unsigned base_cyc,
                                                input int unsigned step_cyc,
                                                input logic [CODE_W-1:0] code);
    return base_cyc + stretch_steps(code) * step_cyc;
  endfunction
endpackage

// File: rtl/rfsh_ctrl_reg.sv
module rfsh_ctrl_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (wr_i) q_o <= wdata_i;
  end

  // R8: the control word moves only on a write
  a_r8_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int unsigned BASE_CYC = 100,
  parameter int unsigned STEP_CYC = 200,
  localparam int unsigned MAX_CYC = BASE_CYC + rfsh_pkg::CODE_MAX * STEP_CYC,
  localparam int CNT_W = $clog2(MAX_CYC + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable_i,
  input  logic [rfsh_pkg::CODE_W-1:0] code_i,
  input  logic                        ack_i,
  output logic                        req_o,
  output logic                        done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             expire;

  assign last_cnt = CNT_W'(rfsh_pkg::period_cycles(BASE_CYC, STEP_CYC, code_i) - 1);
  assign expire   = (cnt_q >= last_cnt);
  assign done_o   = req_o & ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_o <= 1'b0;
    end else if (!enable_i) begin
      cnt_q <= '0;
      req_o <= 1'b0;
    end else if (req_o) begin
      if (ack_i) begin
        req_o <= 1'b0;
        cnt_q <= '0;
      end
    end else if (expire) begin
      req_o <= 1'b1;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1 / R9: no request survives a cleared run bit
  a_r1_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !req_o);
  // R3: a request is held until acknowledged
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i && enable_i) |=> req_o);
  // R4: an acknowledge retires the request
  a_r4_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !req_o);
  // R2: the counter never passes the longest period
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_CYC));
endmodule

// File: rtl/rfsh_status.sv
module rfsh_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R5 / R7: a serviced refresh always leaves the flag set, even against a clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R6: a lone clear empties the flag
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  // R10: the flag rises only with a serviced refresh
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !flag_o) |=> !flag_o);
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
  parameter int unsigned CLK_PERIOD_NS    = 8,
  parameter int unsigned BASE_INTERVAL_NS = 800,
  localparam int unsigned BASE_CYC = BASE_INTERVAL_NS / CLK_PERIOD_NS,
  localparam int unsigned STEP_CYC = rfsh_pkg::STEP_NS / CLK_PERIOD_NS,
  localparam int CTRL_W = rfsh_pkg::CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  input  logic              status_clr,
  input  logic              refresh_ack,
  output logic              refresh_req,
  output logic              refresh_seen
);
  logic run_en;
  logic refresh_done;

  rfsh_ctrl_reg #(.W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(ctrl_wr), .wdata_i(ctrl_wdata), .q_o(ctrl_q)
  );

  assign run_en = ctrl_q[CTRL_W-1];

  rfsh_timer #(.BASE_CYC(BASE_CYC), .STEP_CYC(STEP_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable_i(run_en),
    .code_i(ctrl_q[rfsh_pkg::CODE_W-1:0]), .ack_i(refresh_ack),
    .req_o(refresh_req), .done_o(refresh_done)
  );

  rfsh_status u_status (
    .clk(clk), .rst_n(rst_n), .set_i(refresh_done), .clr_i(status_clr),
    .flag_o(refresh_seen)
  );

  // R5: an acknowledged request marks the flag on the next cycle
  a_r5_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && refresh_ack) |=> refresh_seen);
endmodule

// File: tb/rfsh_sched_tb_top.sv
module rfsh_sched_tb_top;
  localparam int CLK_NS  = 8;
  localparam int BASE_NS = 800;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [3:0] ctrl_wdata = '0;
  logic [3:0] ctrl_q;
  logic       status_clr = 1'b0;
  logic       refresh_ack = 1'b0;
  logic       refresh_req;
  logic       refresh_seen;

  int checks = 0;
  int fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  rfsh_sched #(.CLK_PERIOD_NS(CLK_NS), .BASE_INTERVAL_NS(BASE_NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_q(ctrl_q), .status_clr(status_clr), .refresh_ack(refresh_ack),
    .refresh_req(refresh_req), .refresh_seen(refresh_seen)
  );

  // stimulus table: code and its expected stretch in ns
  localparam logic [2:0] V_CODE [8] = '{3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
  localparam int V_NS [8] = '{0, 1600, 3200, 4800, 6400, 8000, 9600, 11200};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic en, input logic [2:0] code);
    @(negedge clk);
    ctrl_wr = 1'b1;
    ctrl_wdata = {en, code};
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (!refresh_req && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic ack_pulse(input logic with_clr);
    refresh_ack = 1'b1;
    status_clr = with_clr;
    @(negedge clk);
    refresh_ack = 1'b0;
    status_clr = 1'b0;
  endtask

  task automatic clr_pulse();
    @(negedge clk);
    status_clr = 1'b1;
    @(negedge clk);
    status_clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 ctrl after reset", int'(ctrl_q), 0);
    chk("R8 req after reset", int'(refresh_req), 0);
    chk("R8 flag after reset", int'(refresh_seen), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 from a write, R4 from an acknowledge, R5 flag
    for (int i = 0; i < 8; i++) begin
      int exp_cyc;
      exp_cyc = (BASE_NS + V_NS[i]) / CLK_NS;
      write_ctrl(1'b1, V_CODE[i]);
      chk("R8 ctrl readback", int'(ctrl_q), int'({1'b1, V_CODE[i]}));
      measure(n);
      chk("R2 period from write", n, exp_cyc);
      ack_pulse(1'b0);
      chk("R4 req drops after ack", int'(refresh_req), 0);
      chk("R5 flag set by ack", int'(refresh_seen), 1);
      measure(n);
      chk("R4 period from ack", n, exp_cyc);
      ack_pulse(1'b0);
      clr_pulse();
      chk("R6 flag cleared", int'(refresh_seen), 0);
      write_ctrl(1'b0, 3'd7);
    end

    // R1: run bit off
    write_ctrl(1'b0, 3'd7);
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (refresh_req) n++;
    end
    chk("R1 no req while off", n, 0);

    // R10: stray acknowledge
    ack_pulse(1'b0);
    chk("R10 stray ack ignored", int'(refresh_seen), 0);

    // R3: held request, then R9 withdrawal
    write_ctrl(1'b1, 3'd7);
    measure(n);
    chk("R2 code 7 period", n, BASE_NS / CLK_NS);
    repeat (50) @(negedge clk);
    chk("R3 req held without ack", int'(refresh_req), 1);
    write_ctrl(1'b0, 3'd7);
    @(negedge clk);
    chk("R9 req withdrawn", int'(refresh_req), 0);
    chk("R10 no flag from withdrawal", int'(refresh_seen), 0);
    write_ctrl(1'b1, 3'd6);
    measure(n);
    chk("R9 fresh period after re-enable", n, (BASE_NS + 1600) / CLK_NS);

    // R7: set and clear together
    ack_pulse(1'b1);
    chk("R7 set wins over clear", int'(refresh_seen), 1);
    clr_pulse();
    chk("R6 clear after collision", int'(refresh_seen), 0);

    // R8: reset while running
    measure(n);
    ack_pulse(1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 ctrl cleared by reset", int'(ctrl_q), 0);
    chk("R8 flag cleared by reset", int'(refresh_seen), 0);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    chk("R8 no req after reset", int'(refresh_req), 0);

    finish_run();
  end
endmodule